// File: doc/BRIEF.md
# Boot Vector and Code-Map Selector

This block picks where the processor starts after reset and decides whether the top 2K of the 64K code space is served by user flash or by a built-in bootloader ROM. On the first clock edge after reset is released, it captures three strap pins and three stored configuration values: a jump fuse, a boot status byte and a software vector byte. One clock later it commits the start address, the kind of start, and the initial state of the overlay bit.

The strap check has the highest priority. Next come the jump fuse and the status byte, and then the vector byte. The vector byte chooses between the built-in ROM bootloader and a user bootloader whose page is given by that same byte. Once the start address is committed, software can turn the overlay on or off through a write to special-function register A2h. The block also steers every code fetch address to either the ROM or the flash, using the current overlay bit. As a result, the common bootloader entry point at FFF0h reaches the ROM only while the overlay is on.

Top module: `bootsel_top`

## Requirements
- R1: While rstN is low, bootValid, overlayOn and bootSrc are 0 and bootPc is 0000h.
- R2: If strapPsenN=0, strapEa=1 and strapAle=1 at capture, the result is bootSrc=2 (ROM), bootPc=F800h and overlayOn=1, whatever the fuse, status and vector hold.
- R3: Without the strap condition, fuseJump=1 gives bootSrc=1 (user application), bootPc=0000h and overlayOn=0.
- R4: Without the strap condition, fuseJump=0 with bootStatus=00h gives bootSrc=1, bootPc=0000h and overlayOn=0.
- R5: Without the strap condition, fuseJump=0, a non-zero bootStatus and swVector=FCh give bootSrc=2, bootPc=F800h and overlayOn=1.
- R6: In every other case the result is bootSrc=3 (user bootloader), bootPc={swVector,00h} and overlayOn=0.
- R7: Inputs are captured on the first rising edge with rstN high, and later changes do not affect the result. bootValid rises on the second such edge and stays high.
- R8: While bootValid=1, a write (sfrWrEn=1) to sfrAddr=A2h sets overlayOn to bit 5 of sfrWrData from the next edge. Writes to any other address leave overlayOn unchanged.
- R9: Writes made before bootValid=1 have no effect. overlayOn is 0 until bootValid=1, except when the committed start is ROM.
- R10: romSel=1 exactly when overlayOn=1 and fetchAddr is in F800h–FFFFh, and then romAddr=fetchAddr[10:0]. Otherwise flashSel=1 with flashAddr=fetchAddr.
- R11: While bootValid=1, bootPc and bootSrc hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| strapPsenN | input | 1 | Program-strobe strap, active low |
| strapEa | input | 1 | External-access strap |
| strapAle | input | 1 | Address-latch strap (floating reads 1) |
| fuseJump | input | 1 | Stored bootloader-jump fuse |
| bootStatus | input | 8 | Stored boot status byte |
| swVector | input | 8 | Stored software boot vector |
| sfrWrEn | input | 1 | SFR write strobe |
| sfrAddr | input | 8 | SFR write address |
| sfrWrData | input | 8 | SFR write data |
| fetchAddr | input | 16 | Code fetch address |
| bootValid | output | 1 | Start decision committed |
| bootPc | output | 16 | Initial program counter |
| bootSrc | output | 2 | 0 none, 1 user app, 2 ROM, 3 user bootloader |
| overlayOn | output | 1 | ROM overlay enabled |
| romSel | output | 1 | Fetch goes to ROM |
| flashSel | output | 1 | Fetch goes to flash |
| romAddr | output | 11 | ROM word address |
| flashAddr | output | 16 | Flash address |

## Verification
The bench builds the block with its defaults: a 16-bit code space, an 11-bit overlay window, 8-bit configuration bytes and the ROM vector FCh. Because these sizes are small, the bench can sweep every strap combination, both fuse values, four status patterns and all 256 vector values. That sweep reaches every branch of the priority chain, including the vectors next to FCh. Fetch steering is swept in 256-byte steps plus the window edges, with the overlay both on and off. A set of dedicated sequences covers late input changes, SFR writes that arrive too early, and writes to other addresses.

// File: rtl/bootsel_pkg.sv
package bootsel_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_USER  = 2'd1,
    SRC_ROM   = 2'd2,
    SRC_UBOOT = 2'd3
  } bootSrc_e;

  typedef enum logic [1:0] {
    ST_SAMPLE = 2'd0,
    ST_DECIDE = 2'd1,
    ST_RUN    = 2'd2
  } seqState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic capture;
    logic commit;
    logic sfrOpen;
  } ctrlStb_t;
endpackage

// File: rtl/bootsel_ctrl.sv
module bootsel_ctrl
  import bootsel_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  output ctrlStb_t stb,
  output logic     bootValid
);
  seqState_e state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_SAMPLE: stateNext = ST_DECIDE;
      ST_DECIDE: stateNext = ST_RUN;
      ST_RUN:    stateNext = ST_RUN;
      default:   stateNext = ST_SAMPLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_SAMPLE;
    else       state <= stateNext;
  end

  always_comb begin
    stb.capture = (state == ST_SAMPLE);
    stb.commit  = (state == ST_DECIDE);
    stb.sfrOpen = (state == ST_RUN);
    bootValid   = (state == ST_RUN);
  end
endmodule

// File: rtl/bootsel_dp.sv
module bootsel_dp
  import bootsel_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int OVL_W    = 11,
  parameter int CFG_W    = 8,
  parameter int SFR_AW   = 8,
  parameter logic [SFR_AW-1:0] SFR_ADDR = 8'hA2,
  parameter int OVL_BIT  = 5,
  parameter logic [CFG_W-1:0] ROM_VEC = 8'hFC
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStb_t          stb,
  input  logic              strapPsenN,
  input  logic              strapEa,
  input  logic              strapAle,
  input  logic              fuseJump,
  input  logic [CFG_W-1:0]  bootStatus,
  input  logic [CFG_W-1:0]  swVector,
  input  logic              sfrWrEn,
  input  logic [SFR_AW-1:0] sfrAddr,
  input  logic [CFG_W-1:0]  sfrWrData,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic [ADDR_W-1:0] bootPc,
  output logic [1:0]        bootSrc,
  output logic              overlayOn,
  output logic              romSel,
  output logic              flashSel,
  output logic [OVL_W-1:0]  romAddr,
  output logic [ADDR_W-1:0] flashAddr
);
  localparam int HI_W   = ADDR_W - OVL_W;
  localparam int VEC_SH = ADDR_W - CFG_W;
  localparam logic [ADDR_W-1:0] ROM_BASE = {{HI_W{1'b1}}, {OVL_W{1'b0}}};
  localparam logic [CFG_W-1:0]  OVL_MASK = CFG_W'(1) << OVL_BIT;

  // configuration captured on reset release
  logic             hwReqQ, fuseQ;
  logic [CFG_W-1:0] statusQ, vecQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hwReqQ  <= 1'b0;
      fuseQ   <= 1'b0;
      statusQ <= '0;
      vecQ    <= '0;
    end else if (stb.capture) begin
      hwReqQ  <= !strapPsenN && strapEa && strapAle;
      fuseQ   <= fuseJump;
      statusQ <= bootStatus;
      vecQ    <= swVector;
    end
  end

  // prioritised start decision
  bootSrc_e          tgtSrc;
  logic [ADDR_W-1:0] tgtPc;

  always_comb begin
    if (hwReqQ)                 tgtSrc = SRC_ROM;
    else if (fuseQ)             tgtSrc = SRC_USER;
    else if (statusQ == '0)     tgtSrc = SRC_USER;
    else if (vecQ == ROM_VEC)   tgtSrc = SRC_ROM;
    else                        tgtSrc = SRC_UBOOT;
    case (tgtSrc)
      SRC_ROM:   tgtPc = ROM_BASE;
      SRC_UBOOT: tgtPc = {vecQ, {VEC_SH{1'b0}}};
      default:   tgtPc = '0;
    endcase
  end

  logic sfrHit, sfrBit;
  assign sfrHit = stb.sfrOpen && sfrWrEn && (sfrAddr == SFR_ADDR);
  assign sfrBit = |(sfrWrData & OVL_MASK);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bootPc    <= '0;
      bootSrc   <= SRC_NONE;
      overlayOn <= 1'b0;
    end else begin
      if (stb.commit) begin
        bootPc    <= tgtPc;
        bootSrc   <= tgtSrc;
        overlayOn <= (tgtSrc == SRC_ROM);
      end else if (sfrHit) begin
        overlayOn <= sfrBit;
      end
    end
  end

  // fetch steering into the overlay window
  logic inWindow;
  assign inWindow  = (fetchAddr[ADDR_W-1:OVL_W] == {HI_W{1'b1}});
  assign romSel    = overlayOn && inWindow;
  assign flashSel  = !romSel;
  assign romAddr   = fetchAddr[OVL_W-1:0];
  assign flashAddr = fetchAddr;
endmodule

// File: rtl/bootsel_top.sv
module bootsel_top
  import bootsel_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int OVL_W    = 11,
  parameter int CFG_W    = 8,
  parameter int SFR_AW   = 8,
  parameter logic [SFR_AW-1:0] SFR_ADDR = 8'hA2,
  parameter int OVL_BIT  = 5,
  parameter logic [CFG_W-1:0] ROM_VEC = 8'hFC
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              strapPsenN,
  input  logic              strapEa,
  input  logic              strapAle,
  input  logic              fuseJump,
  input  logic [CFG_W-1:0]  bootStatus,
  input  logic [CFG_W-1:0]  swVector,
  input  logic              sfrWrEn,
  input  logic [SFR_AW-1:0] sfrAddr,
  input  logic [CFG_W-1:0]  sfrWrData,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              bootValid,
  output logic [ADDR_W-1:0] bootPc,
  output logic [1:0]        bootSrc,
  output logic              overlayOn,
  output logic              romSel,
  output logic              flashSel,
  output logic [OVL_W-1:0]  romAddr,
  output logic [ADDR_W-1:0] flashAddr
);
  ctrlStb_t stb;

  bootsel_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .bootValid (bootValid)
  );

  bootsel_dp #(
    .ADDR_W  (ADDR_W),
    .OVL_W   (OVL_W),
    .CFG_W   (CFG_W),
    .SFR_AW  (SFR_AW),
    .SFR_ADDR(SFR_ADDR),
    .OVL_BIT (OVL_BIT),
    .ROM_VEC (ROM_VEC)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .strapPsenN (strapPsenN),
    .strapEa    (strapEa),
    .strapAle   (strapAle),
    .fuseJump   (fuseJump),
    .bootStatus (bootStatus),
    .swVector   (swVector),
    .sfrWrEn    (sfrWrEn),
    .sfrAddr    (sfrAddr),
    .sfrWrData  (sfrWrData),
    .fetchAddr  (fetchAddr),
    .bootPc     (bootPc),
    .bootSrc    (bootSrc),
    .overlayOn  (overlayOn),
    .romSel     (romSel),
    .flashSel   (flashSel),
    .romAddr    (romAddr),
    .flashAddr  (flashAddr)
  );
endmodule

// File: rtl/bootsel_chk.sv
module bootsel_chk #(
  parameter int ADDR_W  = 16,
  parameter int OVL_W   = 11,
  parameter int CFG_W   = 8,
  parameter int SFR_AW  = 8,
  parameter logic [SFR_AW-1:0] SFR_ADDR = 8'hA2,
  parameter int OVL_BIT = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              sfrWrEn,
  input logic [SFR_AW-1:0] sfrAddr,
  input logic [CFG_W-1:0]  sfrWrData,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              bootValid,
  input logic [ADDR_W-1:0] bootPc,
  input logic [1:0]        bootSrc,
  input logic              overlayOn,
  input logic              romSel,
  input logic [OVL_W-1:0]  romAddr
);
  localparam int HI_W = ADDR_W - OVL_W;
  localparam logic [ADDR_W-1:0] ROM_BASE = {{HI_W{1'b1}}, {OVL_W{1'b0}}};

  AST_VALID_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    bootValid |=> bootValid); // R7
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rstN)
    bootValid |=> ($stable(bootPc) && $stable(bootSrc))); // R11
  AST_ROM_OVERLAY: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(bootValid) && bootSrc == 2'd2) |-> (overlayOn && bootPc == ROM_BASE)); // R5
  AST_USER_NO_OVERLAY: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(bootValid) && bootSrc != 2'd2) |-> !overlayOn); // R3
  AST_EARLY_OFF: assert property (@(posedge clk) disable iff (!rstN)
    !bootValid |-> !overlayOn); // R9
  AST_SFR_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (bootValid && sfrWrEn && sfrAddr == SFR_ADDR) |=> (overlayOn == $past(sfrWrData[OVL_BIT]))); // R8
  AST_ROM_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    romSel |-> (overlayOn && fetchAddr[ADDR_W-1:OVL_W] == {HI_W{1'b1}} && romAddr == fetchAddr[OVL_W-1:0])); // R10
endmodule

bind bootsel_top bootsel_chk #(
  .ADDR_W (ADDR_W),
  .OVL_W  (OVL_W),
  .CFG_W  (CFG_W),
  .SFR_AW (SFR_AW),
  .SFR_ADDR(SFR_ADDR),
  .OVL_BIT(OVL_BIT)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .sfrWrEn   (sfrWrEn),
  .sfrAddr   (sfrAddr),
  .sfrWrData (sfrWrData),
  .fetchAddr (fetchAddr),
  .bootValid (bootValid),
  .bootPc    (bootPc),
  .bootSrc   (bootSrc),
  .overlayOn (overlayOn),
  .romSel    (romSel),
  .romAddr   (romAddr)
);

// File: tb/sim_bootsel_top.sv
`timescale 1ns/1ps
module sim_bootsel_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        strapPsenN = 1'b1, strapEa = 1'b0, strapAle = 1'b1, fuseJump = 1'b1;
  logic [7:0]  bootStatus = 8'h00, swVector = 8'h00;
  logic        sfrWrEn = 1'b0;
  logic [7:0]  sfrAddr = 8'h00, sfrWrData = 8'h00;
  logic [15:0] fetchAddr = 16'h0000;
  logic        bootValid, overlayOn, romSel, flashSel;
  logic [15:0] bootPc, flashAddr;
  logic [1:0]  bootSrc;
  logic [10:0] romAddr;

  int nChk = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  bootsel_top u0 (
    .clk(clk), .rstN(rstN), .strapPsenN(strapPsenN), .strapEa(strapEa),
    .strapAle(strapAle), .fuseJump(fuseJump), .bootStatus(bootStatus),
    .swVector(swVector), .sfrWrEn(sfrWrEn), .sfrAddr(sfrAddr),
    .sfrWrData(sfrWrData), .fetchAddr(fetchAddr), .bootValid(bootValid),
    .bootPc(bootPc), .bootSrc(bootSrc), .overlayOn(overlayOn),
    .romSel(romSel), .flashSel(flashSel), .romAddr(romAddr),
    .flashAddr(flashAddr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  // expected decision computed from the requirements
  task automatic expect_boot(input logic pn, ea, al, fu, input logic [7:0] st, vec,
                             output logic [15:0] ePc, output logic [1:0] eSrc,
                             output logic eOvl, output string tag);
    if (!pn && ea && al)        begin ePc = 16'hF800; eSrc = 2; eOvl = 1; tag = "R2"; end
    else if (fu)                begin ePc = 16'h0000; eSrc = 1; eOvl = 0; tag = "R3"; end
    else if (st == 8'h00)       begin ePc = 16'h0000; eSrc = 1; eOvl = 0; tag = "R4"; end
    else if (vec == 8'hFC)      begin ePc = 16'hF800; eSrc = 2; eOvl = 1; tag = "R5"; end
    else                        begin ePc = {vec, 8'h00}; eSrc = 3; eOvl = 0; tag = "R6"; end
  endtask

  task automatic start_boot(input logic pn, ea, al, fu, input logic [7:0] st, vec);
    @(negedge clk);
    rstN = 1'b0;
    strapPsenN = pn; strapEa = ea; strapAle = al; fuseJump = fu;
    bootStatus = st; swVector = vec;
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic run_case(input logic pn, ea, al, fu, input logic [7:0] st, vec);
    logic [15:0] ePc; logic [1:0] eSrc; logic eOvl; string tag;
    start_boot(pn, ea, al, fu, st, vec);
    @(posedge clk); @(posedge clk); @(negedge clk);
    expect_boot(pn, ea, al, fu, st, vec, ePc, eSrc, eOvl, tag);
    chk({tag, " pc"}, bootPc, ePc);
    chk({tag, " src"}, bootSrc, eSrc);
    chk({tag, " ovl"}, overlayOn, eOvl);
  endtask

  task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    sfrWrEn = 1'b1; sfrAddr = a; sfrWrData = d;
    @(negedge clk);
    sfrWrEn = 1'b0;
  endtask

  task automatic fetch_sweep(input logic ovl, input string req);
    for (int i = 0; i < 260; i++) begin
      logic [15:0] a;
      logic eRom;
      if (i < 256) a = 16'(i * 256 + (i % 7));
      else if (i == 256) a = 16'hF7FF;
      else if (i == 257) a = 16'hF800;
      else if (i == 258) a = 16'hFFF0;
      else a = 16'hFFFF;
      fetchAddr = a;
      #1;
      eRom = ovl && (a >= 16'hF800);
      chk({req, " romSel"}, romSel, eRom);
      chk({req, " flashSel"}, flashSel, !eRom);
      if (eRom) chk({req, " romAddr"}, romAddr, a - 16'hF800);
      else      chk({req, " flashAddr"}, flashAddr, a);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired R7 act=hung exp=done");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] stSet [4];
    stSet[0] = 8'h00; stSet[1] = 8'h01; stSet[2] = 8'h80; stSet[3] = 8'hFF;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 valid", bootValid, 0);
    chk("R1 ovl", overlayOn, 0);
    chk("R1 pc", bootPc, 0);
    chk("R1 src", bootSrc, 0);

    // R2..R6 sweep of the priority chain
    for (int s = 0; s < 8; s++)
      for (int f = 0; f < 2; f++)
        for (int k = 0; k < 4; k++)
          for (int v = 0; v < 256; v++)
            run_case(s[2], s[1], s[0], f[0], stSet[k], 8'(v));

    // R7 capture timing and hold
    start_boot(1, 0, 1, 1, 8'h00, 8'h00);
    @(posedge clk); @(negedge clk);
    chk("R7 valid after capture edge", bootValid, 0);
    strapPsenN = 0; strapEa = 1; strapAle = 1; fuseJump = 0;
    bootStatus = 8'h55; swVector = 8'hFC;
    @(posedge clk); @(negedge clk);
    chk("R7 valid after commit edge", bootValid, 1);
    chk("R7 pc ignores late inputs", bootPc, 16'h0000);
    chk("R7 src ignores late inputs", bootSrc, 1);
    chk("R7 ovl ignores late inputs", overlayOn, 0);

    // R11 result held while inputs move
    repeat (5) begin
      @(negedge clk);
      swVector = swVector + 8'h13; fuseJump = ~fuseJump;
    end
    chk("R11 pc held", bootPc, 16'h0000);
    chk("R11 src held", bootSrc, 1);
    chk("R7 valid held", bootValid, 1);

    // R10 steering with overlay off
    fetch_sweep(0, "R10 off");

    // R8 writes after boot
    sfr_write(8'hA2, 8'h20);
    chk("R8 set bit5", overlayOn, 1);
    fetch_sweep(1, "R10 on");
    sfr_write(8'hA3, 8'h00);
    chk("R8 other addr ignored", overlayOn, 1);
    sfr_write(8'h22, 8'h00);
    chk("R8 other addr ignored 2", overlayOn, 1);
    sfr_write(8'hA2, 8'hDF);
    chk("R8 clear bit5", overlayOn, 0);
    sfr_write(8'hA3, 8'hFF);
    chk("R8 other addr no set", overlayOn, 0);

    // R9 writes during the decision are ignored
    start_boot(1, 0, 1, 1, 8'h00, 8'h00);
    sfrWrEn = 1'b1; sfrAddr = 8'hA2; sfrWrData = 8'hFF;
    @(posedge clk); @(negedge clk);
    chk("R9 ovl during decide", overlayOn, 0);
    @(posedge clk); @(negedge clk);
    sfrWrEn = 1'b0;
    chk("R9 early write ignored", overlayOn, 0);
    @(negedge clk);
    chk("R9 still off", overlayOn, 0);

    // R8 clear after ROM boot
    run_case(0, 1, 1, 0, 8'h00, 8'h00);
    sfr_write(8'hA2, 8'h00);
    chk("R8 clear after rom boot", overlayOn, 0);
    chk("R11 pc after sfr", bootPc, 16'hF800);

    summary();
    $finish;
  end
endmodule